// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital control of a six-input successive-approximation converter. A host reaches it through an asynchronous port made of an active-low chip select, write strobe and read strobe, plus an 8-bit control byte and a 12-bit result bus that has its own output enable. An active-low interrupt tells the host that a result is waiting. The port pins are first synchronized into the conversion clock domain. A write strobe, seen while chip select is low, stores a control byte. That byte picks the input channel, the span, the polarity, the acquisition scheme, and the clock or power setting.

After a write, the block drives a track request for an acquisition window. The window is either a fixed count of clocks or lasts until a later write closes it. The block then runs a 12-step binary search. On each step it presents a trial code to the converter's DAC, samples the comparator decision, and keeps or drops the trial bit. The finished code is formatted for the chosen polarity, stored, and shown on the bus during reads. The analog mux, track/hold, DAC and comparator sit outside the block. They appear here only as control outputs and the decision input.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A write strobe that rises while chip select is low stores `din`. Bit 5 selects external acquisition and appears on `acq_ext`. Bit 4 selects the wide span and appears on `wide_range`. Bit 3 selects bipolar and appears on `bipolar`. Bits 2:0 are the channel and appear on `mux_sel`.
- R2: A byte with bit 5 clear starts an acquisition. During it `track` is high for exactly 6 clocks, and the conversion then begins without further action.
- R3: A conversion keeps `converting` high for exactly 12 clocks. It resolves the MSB first. The trial bit stays set when `cmp_hi` is 1, meaning the input is at or above `dac_code`, and is cleared otherwise.
- R4: A byte with bit 5 set keeps `track` high for as long as no further write arrives. A later byte with bit 5 clear ends that acquisition and starts a 12-clock conversion.
- R5: If the byte that follows an external acquisition also has bit 5 set, the acquisition restarts and no conversion begins.
- R6: A write that arrives during a conversion aborts it and starts a new acquisition. The aborted conversion never raises the interrupt and never changes the result.
- R7: `irq_n` goes low when a conversion completes. It returns high on the next read, and also on any write.
- R8: While chip select is high, write and read strobes have no effect, and `dout_oe` stays low.
- R9: In unipolar mode the result is the raw search code. In bipolar mode the result is two's complement, which equals the search code with its MSB inverted.
- R10: When the channel code is 6 or 7, the sequence still runs and produces a result, but `mux_en` stays low. For codes 0 to 5, `mux_en` is high during acquisition.
- R11: Bits 7:6 select the clock and power setting. The code 00 means normal operation with the external clock, 01 means internal clock, 10 means standby and 11 means full power-down. The two power-down codes leave the stored clock choice unchanged.
- R12: `dout_oe` is high only while chip select and read are both low, and `dout` then carries the stored result. After reset `irq_n` is high, `track` and `converting` are low, and the setting is normal operation with the external clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| din | input | 8 | Control byte from the host |
| cmp_hi | input | 1 | Comparator decision: input at or above trial code |
| dout | output | 12 | Result toward the host |
| dout_oe | output | 1 | Drive enable for the result bus |
| irq_n | output | 1 | Result-ready interrupt, active low |
| mux_sel | output | 3 | Selected channel |
| mux_en | output | 1 | Analog mux enable |
| track | output | 1 | Track/hold in tracking |
| converting | output | 1 | Binary search running |
| dac_code | output | 12 | Trial code to the DAC |
| bipolar | output | 1 | Bipolar polarity selected |
| wide_range | output | 1 | Wide span selected |
| acq_ext | output | 1 | External acquisition selected |
| clk_internal | output | 1 | Internal conversion clock selected |
| standby | output | 1 | Standby power-down |
| full_off | output | 1 | Full power-down |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a running conversion. It is even harder when the analog level also changes at that moment, because a stale completion is only visible as the wrong result or an early interrupt. To create it, the stimulus watches `converting`, waits a few clocks into the search, changes the modelled input level and writes again. The expected result is then the new level, with a full 6-clock acquisition in front of it. The external-acquisition restart is reached the same way: two bytes with bit 5 set, then one with bit 5 clear. Random runs mix levels, polarities, channels and both acquisition schemes against a comparator model built into the bench.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DATA_W     = 12,
  parameter int ACQ_CYCLES = 6,
  parameter int CH_N       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [7:0]        din,
  input  logic              cmp_hi,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              irq_n,
  output logic [2:0]        mux_sel,
  output logic              mux_en,
  output logic              track,
  output logic              converting,
  output logic [DATA_W-1:0] dac_code,
  output logic              bipolar,
  output logic              wide_range,
  output logic              acq_ext,
  output logic              clk_internal,
  output logic              standby,
  output logic              full_off
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam int CNT_W = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES) : 1;
  localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] LSB_ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_INT, S_EXT, S_CONV} seq_t;

  logic [1:0]        cs_q;
  logic [2:0]        wr_q, rd_q;
  seq_t              state;
  logic [7:0]        ctrl_q;
  logic              clk_int_q;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sar, result;
  logic [DATA_W-1:0] bit_now, sar_kept, sar_nxt;
  logic              cs_on, wr_ev, rd_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 2'b11;
      wr_q <= 3'b111;
      rd_q <= 3'b111;
    end else begin
      cs_q <= {cs_q[0], cs_n};
      wr_q <= {wr_q[1:0], wr_n};
      rd_q <= {rd_q[1:0], rd_n};
    end
  end

  assign cs_on = ~cs_q[1];
  assign wr_ev = cs_on & wr_q[1] & ~wr_q[2];
  assign rd_ev = cs_on & ~rd_q[1] & rd_q[2];

  assign bit_now  = LSB_ONE << idx;
  assign sar_kept = cmp_hi ? sar : (sar & ~bit_now);
  assign sar_nxt  = sar_kept | (bit_now >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ctrl_q    <= '0;
      clk_int_q <= 1'b0;
      cnt       <= '0;
      idx       <= '0;
      sar       <= '0;
      result    <= '0;
      irq_n     <= 1'b1;
    end else begin
      if (rd_ev) irq_n <= 1'b1;
      if (wr_ev) begin
        ctrl_q <= din;
        irq_n  <= 1'b1;
        if (!din[7]) clk_int_q <= din[6];
        if (din[5]) begin
          state <= S_EXT;
        end else if (state == S_EXT) begin
          state <= S_CONV;
          idx   <= IDX_W'(DATA_W-1);
          sar   <= MSB_ONE;
        end else begin
          state <= S_INT;
          cnt   <= '0;
        end
      end else begin
        case (state)
          S_INT: begin
            if (cnt == CNT_W'(ACQ_CYCLES-1)) begin
              state <= S_CONV;
              idx   <= IDX_W'(DATA_W-1);
              sar   <= MSB_ONE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_CONV: begin
            sar <= sar_nxt;
            if (idx == '0) begin
              state  <= S_IDLE;
              result <= ctrl_q[3] ? {~sar_kept[DATA_W-1], sar_kept[DATA_W-2:0]} : sar_kept;
              irq_n  <= 1'b0;
            end else begin
              idx <= idx - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dout_oe      = ~cs_n & ~rd_n;
  assign dout         = dout_oe ? result : '0;
  assign track        = (state == S_INT) || (state == S_EXT);
  assign converting   = (state == S_CONV);
  assign dac_code     = sar;
  assign mux_sel      = ctrl_q[2:0];
  assign mux_en       = track && (ctrl_q[2:0] < 3'(CH_N));
  assign bipolar      = ctrl_q[3];
  assign wide_range   = ctrl_q[4];
  assign acq_ext      = ctrl_q[5];
  assign clk_internal = clk_int_q;
  assign standby      = ctrl_q[7] & ~ctrl_q[6];
  assign full_off     = ctrl_q[7] & ctrl_q[6];

  AST_ACQ_TO_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INT && cnt == CNT_W'(ACQ_CYCLES-1) && !wr_ev) |=> (converting && idx == IDX_W'(DATA_W-1))); // R2
  AST_CONV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CONV && idx != '0 && !wr_ev) |=> (converting && idx == $past(idx) - 1'b1)); // R3
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CONV && idx == '0 && !wr_ev) |=> (!irq_n && state == S_IDLE)); // R7
  AST_WRITE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> (irq_n && !converting || (converting && idx == IDX_W'(DATA_W-1)))); // R6
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXT && !wr_ev) |=> (state == S_EXT)); // R4
  AST_CS_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_on |=> $stable(ctrl_q)); // R8

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] din = '0;
  logic [11:0] target = '0;
  logic [11:0] dout, dac_code;
  logic cmp_hi, dout_oe, irq_n, mux_en, track, converting;
  logic bipolar, wide_range, acq_ext, clk_internal, standby, full_off;
  logic [2:0] mux_sel;
  int checks = 0, errors = 0;
  int acq_n = 0, conv_n = 0, mux_n = 0;
  int b_acq, b_conv, b_mux;
  bit finished = 0;

  always #4 clk = ~clk;
  assign cmp_hi = (dac_code <= target);

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
    .cmp_hi(cmp_hi), .dout(dout), .dout_oe(dout_oe), .irq_n(irq_n),
    .mux_sel(mux_sel), .mux_en(mux_en), .track(track), .converting(converting),
    .dac_code(dac_code), .bipolar(bipolar), .wide_range(wide_range),
    .acq_ext(acq_ext), .clk_internal(clk_internal), .standby(standby),
    .full_off(full_off));

  always @(negedge clk) begin
    if (track) acq_n++;
    if (converting) conv_n++;
    if (track && mux_en) mux_n++;
  end

  function automatic logic [7:0] mk(input logic [1:0] pd, input logic ext, input logic rng,
                                    input logic bip, input logic [2:0] ch);
    return {pd, ext, rng, bip, ch};
  endfunction

  function automatic logic [11:0] expect_res(input logic [11:0] lvl, input logic bip);
    return bip ? {~lvl[11], lvl[10:0]} : lvl;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    din = b; cs_n = 1'b0; wr_n = 1'b0;
    b_acq = acq_n; b_conv = conv_n; b_mux = mux_n;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (irq_n && n < 200) begin @(negedge clk); n++; end
    check(!irq_n, req, irq_n, 0);
  endtask

  task automatic rd(input logic [11:0] exp, input string req);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    #1;
    check(dout_oe == 1'b1, "R12", dout_oe, 1);
    check(dout == exp, req, dout, exp);
    repeat (3) @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    check(irq_n == 1'b1, "R7 read clears", irq_n, 1);
    check(dout_oe == 1'b0, "R12 oe off", dout_oe, 0);
  endtask

  task automatic run_int(input logic [7:0] b, input logic [11:0] lvl);
    target = lvl;
    wr(b);
    wait_done("R2 done");
    check(conv_n - b_conv == 12, "R3 conv length", conv_n - b_conv, 12);
    check(acq_n - b_acq == 6, "R2 acq length", acq_n - b_acq, 6);
    rd(expect_res(lvl, b[3]), "R9 result");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R12 reset state, R11 reset setting
    check(irq_n == 1 && track == 0 && converting == 0, "R12 reset", {irq_n, track, converting}, 3'b100);
    check(clk_internal == 0 && standby == 0 && full_off == 0, "R11 reset", {clk_internal, standby, full_off}, 0);
    check(dout_oe == 0, "R8 idle oe", dout_oe, 0);

    // R1 field mapping, unipolar wide span channel 2
    run_int(mk(2'b00, 1'b0, 1'b1, 1'b0, 3'd2), 12'hABC);
    check(mux_sel == 3'd2 && wide_range && !bipolar && !acq_ext, "R1 fields",
          {mux_sel, wide_range, bipolar, acq_ext}, {3'd2, 3'b100});
    check(mux_n - b_mux > 0, "R10 mux on", mux_n - b_mux, 1);
    // R9 bipolar and range ends
    run_int(mk(2'b00, 1'b0, 1'b0, 1'b1, 3'd1), 12'h123);
    check(bipolar == 1'b1, "R1 bipolar bit", bipolar, 1);
    run_int(mk(2'b00, 1'b0, 1'b0, 1'b1, 3'd1), 12'hFFF);
    run_int(mk(2'b00, 1'b0, 1'b0, 1'b1, 3'd1), 12'h000);
    run_int(mk(2'b00, 1'b0, 1'b0, 1'b0, 3'd0), 12'h000);
    run_int(mk(2'b00, 1'b0, 1'b0, 1'b0, 3'd5), 12'hFFF);

    // R8 strobes with chip select high
    target = 12'h555;
    wr(mk(2'b00, 1'b0, 1'b0, 1'b0, 3'd4));
    wait_done("R8 setup");
    @(negedge clk); wr_n = 1'b0; din = 8'h13;
    repeat (2) @(negedge clk); wr_n = 1'b1;
    repeat (10) @(negedge clk);
    check(track == 0 && converting == 0, "R8 write ignored", {track, converting}, 0);
    check(mux_sel == 3'd4, "R8 byte not stored", mux_sel, 4);
    rd_n = 1'b0; #1;
    check(dout_oe == 0, "R8 oe stays low", dout_oe, 0);
    repeat (5) @(negedge clk); rd_n = 1'b1;
    repeat (3) @(negedge clk);
    check(irq_n == 0, "R8 read ignored", irq_n, 0);
    // R7 write clears pending interrupt
    target = 12'h3C3;
    wr(mk(2'b00, 1'b0, 1'b0, 1'b0, 3'd3));
    check(irq_n == 1, "R7 write clears", irq_n, 1);
    wait_done("R7 done");
    rd(12'h3C3, "R9 after clear");

    // R4 / R5 external acquisition with restart
    target = 12'h7E1;
    wr(mk(2'b00, 1'b1, 1'b0, 1'b0, 3'd3));
    repeat (25) @(negedge clk);
    check(track == 1 && converting == 0 && acq_ext, "R4 held", {track, converting, acq_ext}, 3'b101);
    wr(mk(2'b00, 1'b1, 1'b0, 1'b0, 3'd3));
    repeat (15) @(negedge clk);
    check(track == 1 && converting == 0 && irq_n == 1, "R5 restart", {track, converting, irq_n}, 3'b101);
    wr(mk(2'b00, 1'b0, 1'b0, 1'b0, 3'd3));
    wait_done("R4 done");
    check(conv_n - b_conv == 12, "R4 conv length", conv_n - b_conv, 12);
    rd(12'h7E1, "R4 result");

    // R6 abort mid conversion
    target = 12'h111;
    wr(mk(2'b00, 1'b0, 1'b0, 1'b0, 3'd0));
    while (!converting) @(negedge clk);
    repeat (3) @(negedge clk);
    target = 12'hC0D;
    wr(mk(2'b00, 1'b0, 1'b0, 1'b0, 3'd0));
    check(track == 1 && irq_n == 1, "R6 new acquisition", {track, irq_n}, 2'b11);
    wait_done("R6 done");
    check(acq_n - b_acq == 6, "R6 acq length", acq_n - b_acq, 6);
    rd(12'hC0D, "R6 result");

    // R10 channels 6 and 7
    run_int(mk(2'b00, 1'b0, 1'b0, 1'b0, 3'd6), 12'h246);
    check(mux_n - b_mux == 0 && mux_sel == 3'd6, "R10 ch6 mux off", mux_n - b_mux, 0);
    run_int(mk(2'b00, 1'b0, 1'b0, 1'b1, 3'd7), 12'h9A0);
    check(mux_n - b_mux == 0, "R10 ch7 mux off", mux_n - b_mux, 0);

    // R11 clock and power codes
    run_int(mk(2'b01, 1'b0, 1'b0, 1'b0, 3'd0), 12'h010);
    check(clk_internal && !standby && !full_off, "R11 internal clock", {clk_internal, standby, full_off}, 3'b100);
    run_int(mk(2'b10, 1'b0, 1'b0, 1'b0, 3'd0), 12'h020);
    check(clk_internal && standby && !full_off, "R11 standby keeps clock", {clk_internal, standby, full_off}, 3'b110);
    run_int(mk(2'b11, 1'b0, 1'b0, 1'b0, 3'd0), 12'h030);
    check(clk_internal && !standby && full_off, "R11 full keeps clock", {clk_internal, standby, full_off}, 3'b101);
    run_int(mk(2'b00, 1'b0, 1'b0, 1'b0, 3'd0), 12'h040);
    check(!clk_internal && !standby && !full_off, "R11 external clock", {clk_internal, standby, full_off}, 0);

    // random mix
    for (int k = 0; k < 30; k++) begin
      logic [11:0] lvl;
      logic bip, ext;
      logic [2:0] ch;
      lvl = 12'($urandom);
      bip = 1'($urandom);
      ext = 1'($urandom);
      ch  = 3'($urandom % 6);
      if (ext) begin
        target = lvl;
        wr(mk(2'b00, 1'b1, 1'b0, bip, ch));
        repeat (3 + $urandom % 18) @(negedge clk);
        wr(mk(2'b00, 1'b0, 1'b0, bip, ch));
        wait_done("R4 random");
        check(conv_n - b_conv == 12, "R3 random conv", conv_n - b_conv, 12);
        rd(expect_res(lvl, bip), "R9 random");
      end else begin
        run_int(mk(2'b00, 1'b0, 1'($urandom), bip, ch), lvl);
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule